// File: doc/BRIEF.md
# Receive Frame Buffer for a Time-Slot Serial Line

This block sits between the byte assembler of a time-division-multiplexed serial receiver and a host bus. The line side delivers one byte per handled time slot. A start-of-frame marker comes with the first byte of each frame. The buffer stores the handled slots of a single frame. When the whole frame has arrived, it raises a ready flag and an interrupt line, and the host drains the frame as a burst of byte reads.

The handoff works one whole frame at a time. Ready appears only when a frame is complete. The buffer counts as empty again only after the host has read exactly the number of handled slots. While a frame is held, the line side cannot overwrite it. Bytes that arrive during that time are discarded and recorded in sticky overflow flags. A read of the status word clears those flags.

The number of handled slots is given as a count minus one. It is captured with the start-of-frame byte, so one setting covers both the collection and the draining of that frame.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset, the status word is 0, the interrupt is low, the read-valid flag is low and the read data is 0x00.
- R2: Collection begins only with a byte that carries the start-of-frame marker. Bytes without the marker that arrive while no frame is being collected are ignored. When the handled count (len_m1 + 1, from 1 to 32 bytes) has been stored, status bit 0 (ready) and the interrupt go high on the clock edge that stores the last byte.
- R3: Ready and the interrupt stay high until the host has made exactly the handled count of reads. They fall on the clock edge of the last of those reads.
- R4: Each read strobe made while ready returns the stored bytes in arrival order. The read-valid flag is high and the byte is present from the clock edge that takes the strobe until the next edge.
- R5: A read strobe made while ready is low returns read-valid low and data 0x00. It does not advance the read position.
- R6: Line bytes that arrive while a frame is held are discarded. The held frame then reads back unchanged.
- R7: A start-of-frame byte that arrives while a frame is held sets status bit 2 (frame dropped).
- R8: A line byte that arrives while a frame is held and at least one of its bytes has already been read sets status bit 1 (line overrun).
- R9: Status bits 1 and 2 are sticky. They clear on the edge that takes a status-read strobe, unless a new overflow event occurs on the same edge, in which case that bit stays set.
- R10: A start-of-frame byte that arrives during collection abandons the partial frame and starts a new one at the first position.
- R11: The handled count is captured with the start-of-frame byte. Later changes to len_m1 do not affect the frame that is being collected or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| len_m1 | input | 5 | Handled slot count minus one |
| ln_valid | input | 1 | Line byte present this cycle |
| ln_sof | input | 1 | Line byte is the first of a frame |
| ln_byte | input | 8 | Line byte value |
| rd_stb | input | 1 | Host byte read strobe |
| rd_data | output | 8 | Byte returned to the host |
| rd_valid | output | 1 | rd_data holds a real byte |
| stat_rd | input | 1 | Host status read strobe, clears sticky bits |
| stat | output | 3 | bit0 ready, bit1 line overrun, bit2 frame dropped |
| irq | output | 1 | Frame-ready interrupt |

## Verification
The properties assume that every input is at a defined level from reset onward. They also assume that the host raises rd_stb and stat_rd only as single-cycle strobes, sampled on the rising edge. The bench drives all inputs one time unit after each rising edge, clears them at reset, and changes len_m1 only where a test is meant to show that the captured count is used. The line side is exercised with stray bytes, restarted frames, frames that collide with a held frame, and frames of both minimum and maximum length.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_HOLD = 2'd2
    } rxfb_phase_e;

    typedef struct packed {
        logic buf_ovf;
        logic line_ovf;
        logic ready;
    } rxfb_stat_t;

endpackage

// File: rtl/rxfb_mem.sv
module rxfb_mem #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] row_q [DEPTH];

    // one register row per slot, written when its address is selected
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(g))) begin
                row_q[g] <= wdata;
            end
        end
    end

    assign rdata = row_q[raddr];
endmodule

// File: rtl/rxfb_fill.sv
module rxfb_fill
    import rxfb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ln_valid,
    input  logic          ln_sof,
    input  logic [AW-1:0] len_m1,
    input  logic          drain_done,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic          hold,
    output logic [CW-1:0] len,
    output logic          drop_sof,
    output logic          drop_byte
);
    typedef struct packed {
        rxfb_phase_e   phase;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
    } fill_t;

    fill_t st_d, st_q;
    logic [CW-1:0] idx;
    logic [CW-1:0] nxt;
    logic [CW-1:0] eff_len;

    always_comb begin
        st_d      = st_q;
        we        = 1'b0;
        drop_sof  = 1'b0;
        drop_byte = 1'b0;
        idx       = ln_sof ? '0 : st_q.cnt;
        nxt       = idx + CW'(1);
        eff_len   = ln_sof ? ({1'b0, len_m1} + CW'(1)) : st_q.len;
        waddr     = idx[AW-1:0];
        if (st_q.phase == PH_HOLD) begin
            if (ln_valid) begin
                drop_byte = 1'b1;
                drop_sof  = ln_sof;
            end
            if (drain_done) begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end
        end else if (ln_valid && (ln_sof || st_q.phase == PH_FILL)) begin
            we       = 1'b1;
            st_d.cnt = nxt;
            st_d.len = eff_len;
            if (nxt == eff_len) begin
                st_d.phase = PH_HOLD;
            end else begin
                st_d.phase = PH_FILL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, len: CW'(1)};
        end else begin
            st_q <= st_d;
        end
    end

    assign hold = (st_q.phase == PH_HOLD);
    assign len  = st_q.len;
endmodule

// File: rtl/rxfb_drain.sv
module rxfb_drain #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  logic          hold,
    input  logic [CW-1:0] len,
    input  logic [DW-1:0] mem_data,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          drain_done,
    output logic          started
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
        logic          valid;
    } drain_t;

    drain_t st_d, st_q;
    logic [CW-1:0] nxt;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.data  = '0;
        drain_done = 1'b0;
        nxt        = st_q.cnt + CW'(1);
        if (rd_stb && hold) begin
            st_d.valid = 1'b1;
            st_d.data  = mem_data;
            if (nxt == len) begin
                st_d.cnt   = '0;
                drain_done = 1'b1;
            end else begin
                st_d.cnt = nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr    = st_q.cnt[AW-1:0];
    assign rd_data  = st_q.data;
    assign rd_valid = st_q.valid;
    assign started  = (st_q.cnt != '0);
endmodule

// File: rtl/rxfb_flags.sv
module rxfb_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic set_line,
    input  logic set_buf,
    output logic line_ovf,
    output logic buf_ovf
);
    typedef struct packed {
        logic line_ovf;
        logic buf_ovf;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_rd) begin
            st_d = '0;
        end
        if (set_line) begin
            st_d.line_ovf = 1'b1;
        end
        if (set_buf) begin
            st_d.buf_ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_ovf = st_q.line_ovf;
    assign buf_ovf  = st_q.buf_ovf;
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf
    import rxfb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] len_m1,
    input  logic          ln_valid,
    input  logic          ln_sof,
    input  logic [DW-1:0] ln_byte,
    input  logic          rd_stb,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    input  logic          stat_rd,
    output logic [2:0]    stat,
    output logic          irq
);
    localparam int CW = AW + 1;

    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] mem_data;
    logic          hold;
    logic [CW-1:0] len;
    logic          drop_sof;
    logic          drop_byte;
    logic          drain_done;
    logic          started;
    logic          line_ovf;
    logic          buf_ovf;
    rxfb_stat_t    stat_w;

    rxfb_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (ln_byte),
        .raddr (raddr),
        .rdata (mem_data)
    );

    rxfb_fill #(.DEPTH(DEPTH)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .ln_valid   (ln_valid),
        .ln_sof     (ln_sof),
        .len_m1     (len_m1),
        .drain_done (drain_done),
        .we         (we),
        .waddr      (waddr),
        .hold       (hold),
        .len        (len),
        .drop_sof   (drop_sof),
        .drop_byte  (drop_byte)
    );

    rxfb_drain #(.DEPTH(DEPTH), .DW(DW)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .hold       (hold),
        .len        (len),
        .mem_data   (mem_data),
        .raddr      (raddr),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .drain_done (drain_done),
        .started    (started)
    );

    rxfb_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_rd  (stat_rd),
        .set_line (drop_byte && started),
        .set_buf  (drop_sof),
        .line_ovf (line_ovf),
        .buf_ovf  (buf_ovf)
    );

    always_comb begin
        stat_w.ready    = hold;
        stat_w.line_ovf = line_ovf;
        stat_w.buf_ovf  = buf_ovf;
    end

    assign stat = stat_w;
    assign irq  = hold;
endmodule

// File: rtl/rxfb_chk.sv
module rxfb_chk #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] len_m1,
    input logic          ln_valid,
    input logic          ln_sof,
    input logic [DW-1:0] ln_byte,
    input logic          rd_stb,
    input logic [DW-1:0] rd_data,
    input logic          rd_valid,
    input logic          stat_rd,
    input logic [2:0]    stat,
    input logic          irq
);
    a_r5_valid_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(stat[0]) && $past(rd_stb)));

    a_r5_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    a_r3_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[0] && !rd_stb) |=> stat[0]);

    a_r9_buf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat[2]) && !$past(stat_rd)) |-> stat[2]);

    a_r9_line_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat[1]) && !$past(stat_rd)) |-> stat[1]);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_rd) && !$past(ln_valid)) |-> (stat[2:1] == 2'b00));

    a_r7_drop_needs_sof: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[2]) |-> $past(ln_valid && ln_sof && stat[0]));

    a_r2_ready_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> $past(ln_valid));
endmodule

bind rx_frame_buf rxfb_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (.*);

// File: tb/rx_frame_buf_tb.sv
module rx_frame_buf_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] len_m1 = '0;
    logic       ln_valid = 1'b0;
    logic       ln_sof = 1'b0;
    logic [7:0] ln_byte = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       stat_rd = 1'b0;
    logic [2:0] stat;
    logic       irq;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_buf u_dut (
        .clk(clk), .rst_n(rst_n), .len_m1(len_m1), .ln_valid(ln_valid),
        .ln_sof(ln_sof), .ln_byte(ln_byte), .rd_stb(rd_stb), .rd_data(rd_data),
        .rd_valid(rd_valid), .stat_rd(stat_rd), .stat(stat), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: every valid byte must match the head of the scoreboard (R4)
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected byte", int'(rd_data), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R4 byte order", int'(rd_data), int'(e));
            end
        end
    end

    task automatic send(input int n, input int base, input bit sof, input bit push);
        for (int i = 0; i < n; i++) begin
            ln_valid = 1'b1;
            ln_sof   = sof && (i == 0);
            ln_byte  = 8'(base + i);
            if (push) exp_q.push_back(8'(base + i));
            @(posedge clk); #1;
        end
        ln_valid = 1'b0;
        ln_sof   = 1'b0;
    endtask

    task automatic rd(input int n);
        for (int i = 0; i < n; i++) begin
            rd_stb = 1'b1;
            @(posedge clk); #1;
        end
        rd_stb = 1'b0;
    endtask

    task automatic clr_stat();
        stat_rd = 1'b1;
        @(posedge clk); #1;
        stat_rd = 1'b0;
    endtask

    task automatic chk_stat(input logic [2:0] e, input string req);
        @(negedge clk);
        check(stat == e, req, int'(stat), int'(e));
        check(irq == e[0], req, int'(irq), int'(e[0]));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check(stat == 3'b000 && irq == 1'b0, "R1 status", int'({irq, stat}), 0);
        check(rd_valid == 1'b0 && rd_data == 8'h00, "R1 read port", int'({rd_valid, rd_data}), 0);
        @(posedge clk); #1;

        // R2 basic four-byte frame, ready only after the last byte
        len_m1 = 5'd3;
        send(3, 8'h40, 1'b1, 1'b1);
        chk_stat(3'b000, "R2 not ready early");
        @(posedge clk); #1;
        ln_valid = 1'b1; ln_byte = 8'h43; exp_q.push_back(8'h43);
        @(posedge clk); #1;
        ln_valid = 1'b0;
        chk_stat(3'b001, "R2 ready on last byte");
        @(posedge clk); #1;
        rd(2);
        chk_stat(3'b001, "R3 ready until all read");
        @(posedge clk); #1;
        rd(2);
        chk_stat(3'b000, "R3 empty after exact count");
        @(posedge clk); #1;

        // R5 read while not ready
        rd(1);
        @(negedge clk);
        check(rd_valid == 1'b0 && rd_data == 8'h00, "R5 invalid read", int'({rd_valid, rd_data}), 0);
        @(posedge clk); #1;

        // R2 stray bytes without marker ignored, then a two-byte frame
        len_m1 = 5'd1;
        send(2, 8'hA0, 1'b0, 1'b0);
        chk_stat(3'b000, "R2 stray bytes ignored");
        @(posedge clk); #1;
        send(2, 8'h50, 1'b1, 1'b1);
        chk_stat(3'b001, "R2 two-byte frame");
        @(posedge clk); #1;

        // R6 and R7 frame arriving while one is held
        send(2, 8'h60, 1'b1, 1'b0);
        chk_stat(3'b101, "R7 frame dropped flag");
        @(posedge clk); #1;
        rd(2);
        chk_stat(3'b100, "R6 held frame intact");
        repeat (3) @(posedge clk); #1;
        chk_stat(3'b100, "R9 sticky drop flag");
        @(posedge clk); #1;
        clr_stat();
        chk_stat(3'b000, "R9 cleared by status read");
        @(posedge clk); #1;

        // R8 line overrun after a partial read
        len_m1 = 5'd2;
        send(3, 8'h30, 1'b1, 1'b1);
        rd(1);
        send(1, 8'h99, 1'b0, 1'b0);
        chk_stat(3'b011, "R8 line overrun flag");
        @(posedge clk); #1;
        rd(2);
        clr_stat();
        chk_stat(3'b000, "R9 line flag cleared");
        @(posedge clk); #1;

        // R10 restart on a new marker during collection
        len_m1 = 5'd3;
        send(2, 8'h70, 1'b1, 1'b0);
        send(4, 8'h80, 1'b1, 1'b1);
        chk_stat(3'b001, "R10 restarted frame ready");
        @(posedge clk); #1;
        rd(4);
        chk_stat(3'b000, "R10 restarted frame drained");
        @(posedge clk); #1;

        // R11 count captured with the marker
        len_m1 = 5'd1;
        ln_valid = 1'b1; ln_sof = 1'b1; ln_byte = 8'hC0; exp_q.push_back(8'hC0);
        @(posedge clk); #1;
        len_m1 = 5'd4; ln_sof = 1'b0; ln_byte = 8'hC1; exp_q.push_back(8'hC1);
        @(posedge clk); #1;
        ln_valid = 1'b0;
        chk_stat(3'b001, "R11 captured count fills");
        @(posedge clk); #1;
        rd(2);
        chk_stat(3'b000, "R11 captured count drains");
        @(posedge clk); #1;

        // R2 and R3 maximum frame of 32 bytes
        len_m1 = 5'd31;
        send(32, 8'h00, 1'b1, 1'b1);
        chk_stat(3'b001, "R2 full-size frame");
        @(posedge clk); #1;
        rd(31);
        chk_stat(3'b001, "R3 one byte left");
        @(posedge clk); #1;
        rd(1);
        chk_stat(3'b000, "R3 full-size drained");
        @(posedge clk); #1;

        // R9 set wins over clear on the same edge
        len_m1 = 5'd0;
        send(1, 8'hE0, 1'b1, 1'b1);
        stat_rd = 1'b1; ln_valid = 1'b1; ln_sof = 1'b1; ln_byte = 8'hEE;
        @(posedge clk); #1;
        stat_rd = 1'b0; ln_valid = 1'b0; ln_sof = 1'b0;
        chk_stat(3'b101, "R9 set wins over clear");
        @(posedge clk); #1;
        clr_stat();
        rd(1);
        chk_stat(3'b000, "R9 final clear");

        @(negedge clk);
        check(exp_q.size() == 0, "R4 all bytes returned", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule